// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses the power state of the system. It starts in Run. When the CPU issues a wait-for-interrupt or a wait-for-event request, three control bits decide the sleep depth: deep-sleep, power-down-on-deep-sleep and low-power-regulator-in-stop. In the light state only the CPU clock is gated. In the stop state all core clocks and the high-speed oscillators are off, and the regulator is held in normal or low-power mode. In the standby state the core domain and the regulator are off.

Each depth has its own wakeup sources and its own way back to Run. The light state and the stop state resume without a reset. The stop state first restarts the oscillators and waits a programmable settling time. Standby returns through a fixed-length system reset pulse and sets a sticky flag that a clear input can reset. An entry request is dropped if a wakeup source that would end the target state is already pending.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst`, `mode_o` reads 0. Mode codes are 0 Run, 1 Sleep, 2 Stop (including settling), 3 Standby (including the reset pulse). In Run, all clock and oscillator enables, `reg_on` and `core_pwr_on` are 1, and `reg_lp`, `sys_rst_out` and `standby_flag` are 0.
- R2: In Run, a request (`wfi_req` or `wfe_req`) with `deep_bit`=0 moves to mode 1 on the next edge. In mode 1 only `cpu_clk_en` is 0.
- R3: Sleep entered with `wfi_req` set (it wins over `wfe_req`) ends on `irq_pend`. Sleep entered with only `wfe_req` ends on `evt_pend` only, and `irq_pend` has no effect.
- R4: A request with `deep_bit`=1 and `pdown_bit`=0 enters mode 2. In that mode `cpu_clk_en`, `core_clk_en` and `osc_en` are 0, `reg_on` is 1, and `reg_lp` equals `lpreg_bit` as sampled at entry.
- R5: Stop ends only on `extline_pend`. On the next edge `osc_en` returns to 1 and `reg_lp` to 0. Core clocks stay off for `settle_cycles`+1 cycles, then Run resumes with no reset.
- R6: A request with `deep_bit`=1 and `pdown_bit`=1 enters mode 3. In mode 3, while `sys_rst_out` is 0, `core_pwr_on`, `reg_on`, `osc_en` and both clock enables are 0.
- R7: Standby ends only on a wakeup-pin rising edge, `alarm`, `ext_rst` or `wdog_rst`. `irq_pend`, `evt_pend` and `extline_pend` have no effect in it.
- R8: Leaving Standby drives `sys_rst_out` high for exactly RST_LEN cycles with power, regulator and oscillators on, then returns to Run.
- R9: `standby_flag` is set on leaving Standby and stays set until `flag_clr`. If a set and a clear fall in the same cycle, the set wins.
- R10: A request is ignored, and the block stays in Run, if the target's wakeup source is already pending: `irq_pend` (WFI sleep), `evt_pend` (WFE sleep), `extline_pend` (Stop), or any Standby source (Standby).
- R11: `wkpin` passes through two synchronising flops. A low-to-high change ends Standby on the third clock edge after the pin rises. A pin that stays high gives no new edge and does not wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power/system reset |
| wfi_req | input | 1 | CPU wait-for-interrupt request pulse |
| wfe_req | input | 1 | CPU wait-for-event request pulse |
| deep_bit | input | 1 | Deep-sleep select |
| pdown_bit | input | 1 | Power-down on deep sleep (Standby) select |
| lpreg_bit | input | 1 | Low-power regulator in Stop |
| irq_pend | input | 1 | Any interrupt pending |
| evt_pend | input | 1 | Wakeup event pending |
| extline_pend | input | 1 | Any enabled external line pending |
| wkpin | input | 1 | Asynchronous wakeup pin |
| alarm | input | 1 | Alarm wakeup |
| ext_rst | input | 1 | External reset request |
| wdog_rst | input | 1 | Independent watchdog reset request |
| flag_clr | input | 1 | Write-one-to-clear for the standby flag |
| settle_cycles | input | SETTLE_W | Oscillator settling count after Stop |
| mode_o | output | 2 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| core_clk_en | output | 1 | Other core-domain clock enable |
| osc_en | output | 1 | High-speed oscillators enable |
| reg_on | output | 1 | Regulator on |
| reg_lp | output | 1 | Regulator in low-power mode |
| core_pwr_on | output | 1 | Core domain powered |
| sys_rst_out | output | 1 | System reset pulse |
| standby_flag | output | 1 | Sticky exit-from-Standby flag |

## Verification
The bench builds the block with SETTLE_W=4 and RST_LEN=3. The 4-bit settle field lets both ends of the count be reached in a few cycles: 0 gives a single settling cycle and 15 gives sixteen. RST_LEN=3 keeps every cycle of the reset pulse short enough to check one by one. At these sizes each Standby wakeup source, the two-flop pin delay, and the same-cycle set and clear of the flag fit in short directed runs after the table of entry cases.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_RUN,
        PS_SLEEP,
        PS_STOP,
        PS_SETTLE,
        PS_STBY,
        PS_RSTP
    } pstate_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STOP  = 2'd2,
        MODE_STBY  = 2'd3
    } mode_t;

    typedef struct packed {
        logic cpu_clk;
        logic core_clk;
        logic osc;
        logic reg_on;
        logic reg_lp;
        logic core_pwr;
        logic sys_rst;
    } pctl_t;

    function automatic mode_t mode_of(pstate_t s);
        case (s)
            PS_SLEEP:            return MODE_SLEEP;
            PS_STOP, PS_SETTLE:  return MODE_STOP;
            PS_STBY, PS_RSTP:    return MODE_STBY;
            default:             return MODE_RUN;
        endcase
    endfunction

    function automatic pctl_t ctl_of(pstate_t s, logic lp);
        pctl_t c;
        c = '{cpu_clk: 1'b1, core_clk: 1'b1, osc: 1'b1, reg_on: 1'b1,
              reg_lp: 1'b0, core_pwr: 1'b1, sys_rst: 1'b0};
        case (s)
            PS_SLEEP:  c.cpu_clk = 1'b0;
            PS_STOP: begin
                c.cpu_clk  = 1'b0;
                c.core_clk = 1'b0;
                c.osc      = 1'b0;
                c.reg_lp   = lp;
            end
            PS_SETTLE: begin
                c.cpu_clk  = 1'b0;
                c.core_clk = 1'b0;
            end
            PS_STBY: begin
                c = '0;
            end
            PS_RSTP: begin
                c.cpu_clk  = 1'b0;
                c.core_clk = 1'b0;
                c.sys_rst  = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwr_wk_sync.sv
module pwr_wk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise
);
    localparam int TOT = STAGES + 1;
    logic [TOT-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[TOT-2:0], pin_async};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pwr_dncnt.sv
module pwr_dncnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int RST_LEN  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wfi_req,
    input  logic                wfe_req,
    input  logic                deep_bit,
    input  logic                pdown_bit,
    input  logic                lpreg_bit,
    input  logic                irq_pend,
    input  logic                evt_pend,
    input  logic                extline_pend,
    input  logic                wkpin,
    input  logic                alarm,
    input  logic                ext_rst,
    input  logic                wdog_rst,
    input  logic                flag_clr,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [1:0]          mode_o,
    output logic                cpu_clk_en,
    output logic                core_clk_en,
    output logic                osc_en,
    output logic                reg_on,
    output logic                reg_lp,
    output logic                core_pwr_on,
    output logic                sys_rst_out,
    output logic                standby_flag
);
    localparam int RW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [RW-1:0] RST_LOAD = RW'(RST_LEN - 1);

    pstate_t st_q, st_d;
    logic    evt_mode_q, lp_q, flag_q;
    logic    wk_rise, settle_zero, pulse_zero;
    logic    req, sleep_hit, stby_hit;
    logic    settle_ld, pulse_ld;
    pctl_t   ctl;

    pwr_wk_sync #(.STAGES(2)) u_wk (
        .clk(clk), .rst(rst), .pin_async(wkpin), .rise(wk_rise)
    );

    pwr_dncnt #(.W(SETTLE_W)) u_settle (
        .clk(clk), .rst(rst), .load(settle_ld), .load_val(settle_cycles),
        .dec(st_q == PS_SETTLE), .zero(settle_zero)
    );

    pwr_dncnt #(.W(RW)) u_pulse (
        .clk(clk), .rst(rst), .load(pulse_ld), .load_val(RST_LOAD),
        .dec(st_q == PS_RSTP), .zero(pulse_zero)
    );

    assign req       = wfi_req | wfe_req;
    assign sleep_hit = wfi_req ? irq_pend : evt_pend;
    assign stby_hit  = wk_rise | alarm | ext_rst | wdog_rst;

    always_comb begin
        st_d = st_q;
        case (st_q)
            PS_RUN: begin
                if (req) begin
                    if (!deep_bit) begin
                        if (!sleep_hit) st_d = PS_SLEEP;
                    end else if (!pdown_bit) begin
                        if (!extline_pend) st_d = PS_STOP;
                    end else if (!stby_hit) begin
                        st_d = PS_STBY;
                    end
                end
            end
            PS_SLEEP:  if (evt_mode_q ? evt_pend : irq_pend) st_d = PS_RUN;
            PS_STOP:   if (extline_pend) st_d = PS_SETTLE;
            PS_SETTLE: if (settle_zero) st_d = PS_RUN;
            PS_STBY:   if (stby_hit) st_d = PS_RSTP;
            PS_RSTP:   if (pulse_zero) st_d = PS_RUN;
            default:   st_d = PS_RUN;
        endcase
    end

    assign settle_ld = (st_q == PS_STOP) && (st_d == PS_SETTLE);
    assign pulse_ld  = (st_q == PS_STBY) && (st_d == PS_RSTP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_RUN;
            evt_mode_q <= 1'b0;
            lp_q       <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == PS_RUN && st_d == PS_SLEEP) evt_mode_q <= ~wfi_req;
            if (st_q == PS_RUN && st_d == PS_STOP)  lp_q <= lpreg_bit;
            if (pulse_ld)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign ctl          = ctl_of(st_q, lp_q);
    assign mode_o       = mode_of(st_q);
    assign cpu_clk_en   = ctl.cpu_clk;
    assign core_clk_en  = ctl.core_clk;
    assign osc_en       = ctl.osc;
    assign reg_on       = ctl.reg_on;
    assign reg_lp       = ctl.reg_lp;
    assign core_pwr_on  = ctl.core_pwr;
    assign sys_rst_out  = ctl.sys_rst;
    assign standby_flag = flag_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_o,
    input logic       cpu_clk_en,
    input logic       core_clk_en,
    input logic       osc_en,
    input logic       reg_on,
    input logic       reg_lp,
    input logic       core_pwr_on,
    input logic       sys_rst_out,
    input logic       standby_flag,
    input logic       flag_clr
);
    a_r1_run_all_on: assert property (@(posedge clk) disable iff (rst)
        mode_o == 2'd0 |-> cpu_clk_en && core_clk_en && osc_en && reg_on
                           && core_pwr_on && !reg_lp && !sys_rst_out);

    a_r2_sleep_cpu_only: assert property (@(posedge clk) disable iff (rst)
        mode_o == 2'd1 |-> !cpu_clk_en && core_clk_en && osc_en && core_pwr_on);

    a_r4_stop_reg_kept: assert property (@(posedge clk) disable iff (rst)
        mode_o == 2'd2 && !osc_en |-> reg_on && !core_clk_en && !cpu_clk_en);

    a_r5_settle_clk_off: assert property (@(posedge clk) disable iff (rst)
        mode_o == 2'd2 && osc_en |-> !core_clk_en && !reg_lp);

    a_r6_standby_dark: assert property (@(posedge clk) disable iff (rst)
        mode_o == 2'd3 && !sys_rst_out |-> !core_pwr_on && !reg_on && !osc_en);

    a_r8_pulse_from_standby: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_out) |-> $past(mode_o) == 2'd3 && standby_flag);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr && mode_o != 2'd3 |=> !standby_flag);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk chk_i (
    .clk(clk), .rst(rst), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
    .core_clk_en(core_clk_en), .osc_en(osc_en), .reg_on(reg_on),
    .reg_lp(reg_lp), .core_pwr_on(core_pwr_on), .sys_rst_out(sys_rst_out),
    .standby_flag(standby_flag), .flag_clr(flag_clr)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
    localparam int SW = 4;
    localparam int RL = 3;

    logic clk = 1'b0;
    logic rst;
    logic wfi_req, wfe_req, deep_bit, pdown_bit, lpreg_bit;
    logic irq_pend, evt_pend, extline_pend, wkpin, alarm, ext_rst, wdog_rst, flag_clr;
    logic [SW-1:0] settle_cycles;
    logic [1:0] mode_o;
    logic cpu_clk_en, core_clk_en, osc_en, reg_on, reg_lp, core_pwr_on, sys_rst_out, standby_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwr_mode_seq #(.SETTLE_W(SW), .RST_LEN(RL)) dut_i (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .deep_bit(deep_bit), .pdown_bit(pdown_bit), .lpreg_bit(lpreg_bit),
        .irq_pend(irq_pend), .evt_pend(evt_pend), .extline_pend(extline_pend),
        .wkpin(wkpin), .alarm(alarm), .ext_rst(ext_rst), .wdog_rst(wdog_rst),
        .flag_clr(flag_clr), .settle_cycles(settle_cycles), .mode_o(mode_o),
        .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en), .osc_en(osc_en),
        .reg_on(reg_on), .reg_lp(reg_lp), .core_pwr_on(core_pwr_on),
        .sys_rst_out(sys_rst_out), .standby_flag(standby_flag)
    );

    // vector: wfi wfe deep pdown lp irq evt ext alarm | exp_mode[1:0]
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {9'b1_0_0_0_0_0_0_0_0, 2'd1},  // R2 WFI sleep
        {9'b0_1_0_0_0_0_0_0_0, 2'd1},  // R2 WFE sleep
        {9'b1_0_1_0_0_0_0_0_0, 2'd2},  // R4 stop, normal regulator
        {9'b0_1_1_0_1_0_0_0_0, 2'd2},  // R4 stop, low-power regulator
        {9'b1_0_1_1_0_0_0_0_0, 2'd3},  // R6 standby
        {9'b1_0_0_0_0_1_0_0_0, 2'd0},  // R10 irq pending blocks WFI sleep
        {9'b0_1_0_0_0_1_0_0_0, 2'd1},  // R10 irq does not block WFE sleep
        {9'b0_1_0_0_0_0_1_0_0, 2'd0},  // R10 event blocks WFE sleep
        {9'b1_0_1_0_0_0_0_1_0, 2'd0},  // R10 ext line blocks stop
        {9'b1_0_1_0_0_1_0_0_0, 2'd2},  // R10 irq does not block stop
        {9'b1_0_1_1_0_0_0_0_1, 2'd0},  // R10 alarm blocks standby
        {9'b1_0_1_1_0_0_0_1_0, 2'd3}   // R10 ext line does not block standby
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic request(input logic wfi, input logic deep, input logic pd, input logic lp);
        wfi_req = wfi; wfe_req = ~wfi; deep_bit = deep; pdown_bit = pd; lpreg_bit = lp;
        tick(1);
        wfi_req = 0; wfe_req = 0;
    endtask

    task automatic wake_all();
        irq_pend = 1; evt_pend = 1; extline_pend = 1; alarm = 1;
        tick(1);
        irq_pend = 0; evt_pend = 0; extline_pend = 0; alarm = 0;
        tick(24);
        flag_clr = 1; tick(1); flag_clr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; wfi_req = 0; wfe_req = 0; deep_bit = 0; pdown_bit = 0; lpreg_bit = 0;
        irq_pend = 0; evt_pend = 0; extline_pend = 0; wkpin = 0; alarm = 0;
        ext_rst = 0; wdog_rst = 0; flag_clr = 0; settle_cycles = 4'd2;
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        check("R1 mode", mode_o, 0);
        check("R1 enables", {cpu_clk_en, core_clk_en, osc_en, reg_on, core_pwr_on}, 5'b11111);
        check("R1 lp/rst/flag", {reg_lp, sys_rst_out, standby_flag}, 3'b000);

        // table of entry decisions
        for (int v = 0; v < NV; v++) begin
            wfi_req = VEC[v][10]; wfe_req = VEC[v][9]; deep_bit = VEC[v][8];
            pdown_bit = VEC[v][7]; lpreg_bit = VEC[v][6]; irq_pend = VEC[v][5];
            evt_pend = VEC[v][4]; extline_pend = VEC[v][3]; alarm = VEC[v][2];
            tick(1);
            wfi_req = 0; wfe_req = 0; irq_pend = 0; evt_pend = 0;
            extline_pend = 0; alarm = 0; lpreg_bit = 0;
            check($sformatf("R10 entry vector %0d mode", v), mode_o, VEC[v][1:0]);
            if (VEC[v][1:0] == 2'd1)
                check("R2 sleep gating", {cpu_clk_en, core_clk_en, osc_en}, 3'b011);
            if (VEC[v][1:0] == 2'd2)
                check("R4 stop outputs", {core_clk_en, osc_en, reg_on, reg_lp}, {3'b001, VEC[v][6]});
            if (VEC[v][1:0] == 2'd3)
                check("R6 standby outputs", {core_pwr_on, reg_on, osc_en, cpu_clk_en}, 4'b0000);
            wake_all();
            check("R1 back in run", mode_o, 0);
        end

        // R3 WFE sleep ignores irq, wakes on event
        request(1'b0, 1'b0, 1'b0, 1'b0);
        irq_pend = 1; tick(3);
        check("R3 irq ignored in WFE sleep", mode_o, 1);
        irq_pend = 0; evt_pend = 1; tick(1); evt_pend = 0;
        check("R3 event wakes WFE sleep", mode_o, 0);
        // R3 WFI sleep wakes on irq
        request(1'b1, 1'b0, 1'b0, 1'b0);
        evt_pend = 1; tick(2);
        check("R3 event ignored in WFI sleep", mode_o, 1);
        evt_pend = 0; irq_pend = 1; tick(1); irq_pend = 0;
        check("R3 irq wakes WFI sleep", mode_o, 0);

        // R5 stop with maximum settle count
        settle_cycles = 4'd15;
        request(1'b1, 1'b1, 1'b0, 1'b1);
        check("R4 lp regulator in stop", {reg_lp, osc_en}, 2'b10);
        irq_pend = 1; alarm = 1; tick(3); irq_pend = 0; alarm = 0;
        check("R5 irq/alarm ignored in stop", {mode_o, osc_en}, {2'd2, 1'b0});
        extline_pend = 1; tick(1); extline_pend = 0;
        check("R5 osc back after ext line", {mode_o, osc_en, core_clk_en, reg_lp}, {2'd2, 3'b100});
        for (int i = 0; i < 15; i++) begin
            tick(1);
            check("R5 core clocks held during settle", core_clk_en, 0);
        end
        tick(1);
        check("R5 run after 16 settle cycles", {mode_o, core_clk_en, sys_rst_out}, {2'd0, 2'b10});

        // R5 settle count zero
        settle_cycles = 4'd0;
        request(1'b1, 1'b1, 1'b0, 1'b0);
        extline_pend = 1; tick(1); extline_pend = 0;
        check("R5 zero settle first cycle", {mode_o, core_clk_en}, {2'd2, 1'b0});
        tick(1);
        check("R5 zero settle resumes", mode_o, 0);

        // R11/R7/R8 standby via wakeup pin
        request(1'b1, 1'b1, 1'b1, 1'b0);
        irq_pend = 1; evt_pend = 1; extline_pend = 1; tick(3);
        irq_pend = 0; evt_pend = 0; extline_pend = 0;
        check("R7 core sources ignored in standby", {mode_o, sys_rst_out}, {2'd3, 1'b0});
        wkpin = 1; tick(1);
        check("R11 pin edge 1", {mode_o, sys_rst_out}, {2'd3, 1'b0});
        tick(1);
        check("R11 pin edge 2", {mode_o, sys_rst_out}, {2'd3, 1'b0});
        tick(1);
        check("R11 wake on third edge", sys_rst_out, 1);
        check("R9 flag set on exit", standby_flag, 1);
        check("R8 power during pulse", {core_pwr_on, reg_on, osc_en}, 3'b111);
        tick(1); check("R8 pulse cycle 2", sys_rst_out, 1);
        tick(1); check("R8 pulse cycle 3", sys_rst_out, 1);
        tick(1); check("R8 pulse ends, run", {mode_o, sys_rst_out}, {2'd0, 1'b0});
        check("R9 flag sticky", standby_flag, 1);

        // R11 pin held high: no edge, no wake; R7 ext_rst wakes
        request(1'b1, 1'b1, 1'b1, 1'b0);
        tick(5);
        check("R11 held pin does not wake", mode_o, 3);
        ext_rst = 1; tick(1); ext_rst = 0;
        check("R7 ext_rst wakes standby", sys_rst_out, 1);
        tick(3);
        check("R8 run after ext_rst pulse", mode_o, 0);

        // R7 watchdog wakes; R9 set wins over clear
        request(1'b1, 1'b1, 1'b1, 1'b0);
        wdog_rst = 1; flag_clr = 1; tick(1); wdog_rst = 0; flag_clr = 0;
        check("R7 wdog wakes standby", sys_rst_out, 1);
        check("R9 set wins over clear", standby_flag, 1);
        tick(3);
        flag_clr = 1; tick(1); flag_clr = 0;
        check("R9 clear", standby_flag, 0);
        wkpin = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule